// File: doc/BRIEF.md
# Dual-Mode Bidirectional Bus Register

This block passes data between an A bus and a B bus through two storage elements per half, one for each direction. Each element follows its input while its latch enable is high. While the latch enable is low it stores the input on a rising edge of its own capture clock, and otherwise keeps what it has. The output enables are active-low and work apart from the data: turning a bus off clears nothing.

The 18-bit path is made of two 9-bit halves. Each half has its own enables and capture clocks, so the path can act as one wide register when the controls of both halves are tied together, or as two narrow ones. The capture clocks are treated as sampled control levels inside one system clock domain. Data is level-based, so there is no valid/ready handshake and no back-pressure: an output bus shows the current followed or stored word in every cycle. Tri-state is modelled as a data word plus one drive flag per half.

Top module: `bus_xcvr`

## Requirements
- R1: While `le_ab[h]` is 1, half h of `b_out` equals half h of `a_in` in the same cycle (half h is bits h*9 to h*9+8).
- R2: While `le_ab[h]` is 0, a change of `ck_ab[h]` from 0 to 1 stores half h of `a_in`. The stored word shows on `b_out` after the next rising edge of `clk`.
- R3: While `le_ab[h]` is 0 and `ck_ab[h]` stays at one level, half h of `b_out` keeps its stored word even when `a_in` changes.
- R4: When `le_ab[h]` goes from 1 to 0 with no capture edge, `b_out` keeps the word that `a_in` held in the last cycle with the latch enable high.
- R5: A rising `ck_ab[h]` while `le_ab[h]` is 1 has no extra effect: `b_out` keeps following `a_in`.
- R6: `b_drv[h]` is 1 exactly when `oe_ab_n[h]` is 0, and `a_drv[h]` is 1 exactly when `oe_ba_n[h]` is 0. Disabling an output leaves its stored word unchanged, so it shows again when re-enabled.
- R7: The B-to-A direction behaves as in R1 to R5, using `le_ba`, `ck_ba`, `b_in` and `a_out`.
- R8: Each half responds only to its own control bits. Activity on one half leaves the other half's outputs unchanged.
- R9: While `rst_n` is 0, both stored words in every half are 0. An output whose latch enable is 0 then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples capture clocks and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset of storage |
| a_in | input | 18 | Word arriving from the A bus |
| b_in | input | 18 | Word arriving from the B bus |
| oe_ab_n | input | 2 | Per-half active-low drive enable of the B side |
| oe_ba_n | input | 2 | Per-half active-low drive enable of the A side |
| le_ab | input | 2 | Per-half latch enable, A to B |
| le_ba | input | 2 | Per-half latch enable, B to A |
| ck_ab | input | 2 | Per-half capture clock, A to B |
| ck_ba | input | 2 | Per-half capture clock, B to A |
| b_out | output | 18 | Word presented to the B bus |
| b_drv | output | 2 | Per-half B side drive flag |
| a_out | output | 18 | Word presented to the A bus |
| a_drv | output | 2 | Per-half A side drive flag |

## Verification
The follow path and the drive flags respond in the same cycle as their inputs. A capture edge on a capture clock shows after one rising edge of `clk`. A latch-enable fall holds the word from the cycle before. The bench drives every vector on the falling edge of `clk` and samples 2 ns after the next rising edge. Its reference model updates its stored words once per rising edge, so every result is compared in the first cycle in which it is due. Random sequences never enable both sides of a half at once, and the bench flags any half whose two drive flags are seen together.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DEF_WIDTH  = 18;
  localparam int DEF_HALVES = 2;

  typedef enum logic [1:0] {
    MODE_FOLLOW = 2'd0,
    MODE_EDGE   = 2'd1,
    MODE_HOLD   = 2'd2
  } cell_mode_e;

  function automatic cell_mode_e pick_mode(input logic le, input logic ck, input logic ck_q);
    if (le)              return MODE_FOLLOW;
    else if (ck && !ck_q) return MODE_EDGE;
    else                 return MODE_HOLD;
  endfunction
endpackage

// File: rtl/xcvr_cell.sv
module xcvr_cell
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         ck,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic         ck_q;
  logic [W-1:0] store;
  cell_mode_e   mode;

  assign mode = pick_mode(le, ck, ck_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b0;
      store <= '0;
    end else begin
      ck_q <= ck;
      if (mode != MODE_HOLD) store <= din;
    end
  end

  assign dout = (mode == MODE_FOLLOW) ? din : store;
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         oe_ab_n,
  input  logic         oe_ba_n,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         ck_ab,
  input  logic         ck_ba,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  xcvr_cell #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .le(le_ab), .ck(ck_ab), .din(a_in), .dout(b_out)
  );
  xcvr_cell #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .le(le_ba), .ck(ck_ba), .din(b_in), .dout(a_out)
  );

  assign b_drv = ~oe_ab_n;
  assign a_drv = ~oe_ba_n;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = DEF_WIDTH,
  parameter int HALVES = DEF_HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  a_in,
  input  logic [WIDTH-1:0]  b_in,
  input  logic [HALVES-1:0] oe_ab_n,
  input  logic [HALVES-1:0] oe_ba_n,
  input  logic [HALVES-1:0] le_ab,
  input  logic [HALVES-1:0] le_ba,
  input  logic [HALVES-1:0] ck_ab,
  input  logic [HALVES-1:0] ck_ba,
  output logic [WIDTH-1:0]  b_out,
  output logic [HALVES-1:0] b_drv,
  output logic [WIDTH-1:0]  a_out,
  output logic [HALVES-1:0] a_drv
);
  localparam int HW = WIDTH / HALVES;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half #(.W(HW)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_in   (a_in[h*HW +: HW]),
      .b_in   (b_in[h*HW +: HW]),
      .oe_ab_n(oe_ab_n[h]),
      .oe_ba_n(oe_ba_n[h]),
      .le_ab  (le_ab[h]),
      .le_ba  (le_ba[h]),
      .ck_ab  (ck_ab[h]),
      .ck_ba  (ck_ba[h]),
      .b_out  (b_out[h*HW +: HW]),
      .b_drv  (b_drv[h]),
      .a_out  (a_out[h*HW +: HW]),
      .a_drv  (a_drv[h])
    );
  end
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int WIDTH  = 18,
  parameter int HALVES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIDTH-1:0]  a_in,
  input logic [WIDTH-1:0]  b_in,
  input logic [HALVES-1:0] oe_ab_n,
  input logic [HALVES-1:0] oe_ba_n,
  input logic [HALVES-1:0] le_ab,
  input logic [HALVES-1:0] le_ba,
  input logic [HALVES-1:0] ck_ab,
  input logic [HALVES-1:0] ck_ba,
  input logic [WIDTH-1:0]  b_out,
  input logic [HALVES-1:0] b_drv,
  input logic [WIDTH-1:0]  a_out,
  input logic [HALVES-1:0] a_drv
);
  localparam int HW = WIDTH / HALVES;

  logic [HALVES-1:0] seen_ab, seen_ba;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ab <= '0;
      seen_ba <= '0;
    end else begin
      seen_ab <= ck_ab;
      seen_ba <= ck_ba;
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    // R2: capture edge stores the input word
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab[h] && ck_ab[h] && !seen_ab[h]) |=>
        (le_ab[h] || b_out[h*HW +: HW] == $past(a_in[h*HW +: HW])));
    // R3: steady capture clock keeps the word
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab[h] && !(ck_ab[h] && !seen_ab[h])) |=>
        (le_ab[h] || b_out[h*HW +: HW] == $past(b_out[h*HW +: HW])));
    // R4: latch-enable fall keeps last followed word
    p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      le_ab[h] |=> (le_ab[h] || b_out[h*HW +: HW] == $past(a_in[h*HW +: HW])));
    // R7: the same three rules for B to A
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ba[h] && ck_ba[h] && !seen_ba[h]) |=>
        (le_ba[h] || a_out[h*HW +: HW] == $past(b_in[h*HW +: HW])));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ba[h] && !(ck_ba[h] && !seen_ba[h])) |=>
        (le_ba[h] || a_out[h*HW +: HW] == $past(a_out[h*HW +: HW])));
    p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      le_ba[h] |=> (le_ba[h] || a_out[h*HW +: HW] == $past(b_in[h*HW +: HW])));
    // R9: storage reads zero during reset
    p_reset_r9: assert property (@(posedge clk)
      (!rst_n && !le_ab[h] && !le_ba[h]) |->
        (b_out[h*HW +: HW] == '0 && a_out[h*HW +: HW] == '0));
  end
endmodule

bind bus_xcvr bus_xcvr_chk #(.WIDTH(WIDTH), .HALVES(HALVES)) u_chk (.*);

// File: tb/sim_bus_xcvr.sv
module sim_bus_xcvr;
  localparam int W  = 18;
  localparam int H  = 2;
  localparam int HW = W / H;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic [H-1:0] oe_ab_n, oe_ba_n, le_ab, le_ba, ck_ab, ck_ba;
  logic [W-1:0] b_out, a_out;
  logic [H-1:0] b_drv, a_drv;

  bus_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .le_ab(le_ab), .le_ba(le_ba),
    .ck_ab(ck_ab), .ck_ba(ck_ba), .b_out(b_out), .b_drv(b_drv),
    .a_out(a_out), .a_drv(a_drv)
  );

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 1'b0;
  logic [HW-1:0] st_ab [H];
  logic [HW-1:0] st_ba [H];
  logic          pk_ab [H];
  logic          pk_ba [H];

  function automatic logic [HW-1:0] nxt(input logic le, input logic ck, input logic pk,
                                        input logic [HW-1:0] din, input logic [HW-1:0] st);
    if (le) return din;
    if (ck && !pk) return din;
    return st;
  endfunction

  function automatic logic [W-1:0] exp_b();
    logic [W-1:0] e;
    for (int h = 0; h < H; h++) e[h*HW +: HW] = le_ab[h] ? a_in[h*HW +: HW] : st_ab[h];
    return e;
  endfunction

  function automatic logic [W-1:0] exp_a();
    logic [W-1:0] e;
    for (int h = 0; h < H; h++) e[h*HW +: HW] = le_ba[h] ? b_in[h*HW +: HW] : st_ba[h];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int h = 0; h < H; h++) begin
      if (!rst_n) begin
        st_ab[h] = '0; st_ba[h] = '0; pk_ab[h] = 1'b0; pk_ba[h] = 1'b0;
      end else begin
        st_ab[h] = nxt(le_ab[h], ck_ab[h], pk_ab[h], a_in[h*HW +: HW], st_ab[h]);
        st_ba[h] = nxt(le_ba[h], ck_ba[h], pk_ba[h], b_in[h*HW +: HW], st_ba[h]);
        pk_ab[h] = ck_ab[h];
        pk_ba[h] = ck_ba[h];
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    chk({tag, " b_out"}, b_out, exp_b());
    chk({tag, " a_out"}, a_out, exp_a());
    chk({tag, " R6 drive"}, W'({b_drv, a_drv}), W'({~oe_ab_n, ~oe_ba_n}));
    vectors++;
    if ((a_drv & b_drv) != '0) begin
      miscmp++;
      $display("FAIL R6 contention act=%b exp=%b", a_drv & b_drv, {H{1'b0}});
    end
  endtask

  logic [W-1:0] keep;

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0;
    oe_ab_n = '1; oe_ba_n = '1; le_ab = '0; le_ba = '0; ck_ab = '0; ck_ba = '0;
    for (int h = 0; h < H; h++) begin
      st_ab[h] = '0; st_ba[h] = '0; pk_ab[h] = 1'b0; pk_ba[h] = 1'b0;
    end
    void'($urandom(32'h5eed_0042));
    @(negedge clk); a_in = W'($urandom); b_in = W'($urandom); step("R9 reset");
    @(negedge clk); step("R9 reset");
    @(negedge clk); rst_n = 1'b1; step("R9 after release");

    // R1 follow, R4 fall, R3 hold, R2 capture
    @(negedge clk); le_ab = '1; oe_ab_n = '0; a_in = 18'h2A5C3; step("R1 follow");
    @(negedge clk); a_in = 18'h1F00E; step("R1 follow change");
    @(negedge clk); le_ab = '0; a_in = 18'h0BEEF; step("R4 fall");
    @(negedge clk); a_in = 18'h33333; step("R3 hold ck low");
    @(negedge clk); ck_ab = '1; a_in = 18'h15A5A; step("R2 capture");
    @(negedge clk); a_in = 18'h00FFF; step("R3 hold ck high");
    // R5 edge while following
    @(negedge clk); le_ab = '1; ck_ab = '0; a_in = 18'h12345; step("R5 follow");
    @(negedge clk); ck_ab = '1; a_in = 18'h2DCBA; step("R5 edge while le");
    @(negedge clk); a_in = 18'h0F0F0; step("R5 still follows");
    // R6 disable keeps store
    @(negedge clk); le_ab = '0; ck_ab = '0; step("R6 hold");
    keep = b_out;
    @(negedge clk); oe_ab_n = '1; a_in = 18'h3FFFF; step("R6 disabled");
    @(negedge clk); oe_ab_n = '0; a_in = 18'h00001; step("R6 reenabled");
    chk("R6 reenable shows held", b_out, keep);
    // R7 B to A direction
    @(negedge clk); oe_ab_n = '1; oe_ba_n = '0; le_ba = '1; b_in = 18'h25B6D; step("R7 follow");
    @(negedge clk); le_ba = '0; b_in = 18'h1C71C; step("R7 fall");
    @(negedge clk); ck_ba = '1; b_in = 18'h0A0A0; step("R7 capture");
    // R8 only half 1 captures
    @(negedge clk); ck_ab = 2'b00; a_in = 18'h11111; step("R8 setup");
    keep = b_out;
    @(negedge clk); ck_ab = 2'b10; a_in = 18'h3C3C3; step("R8 half1 edge");
    chk("R8 half0 unchanged", {9'h0, b_out[HW-1:0]}, {9'h0, keep[HW-1:0]});

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      a_in = W'($urandom); b_in = W'($urandom);
      for (int h = 0; h < H; h++) begin
        int sel;
        le_ab[h] = ($urandom % 4) == 0;
        le_ba[h] = ($urandom % 4) == 0;
        if ($urandom % 2) ck_ab[h] = ~ck_ab[h];
        if ($urandom % 2) ck_ba[h] = ~ck_ba[h];
        sel = $urandom % 3;
        oe_ab_n[h] = (sel != 1);
        oe_ba_n[h] = (sel != 2);
      end
      step("R1/R2/R3/R4/R7/R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      vectors++;
      miscmp++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule